// File: doc/BRIEF.md
# Shared SRAM Two-Master Slot Sequencer

This block lets two processors that run on a common bus cycle take turns on one asynchronous SRAM. It runs from a fast tick clock and divides each cycle of a slower phase reference into a frame of 36 equal slots. Slot 0 is locked to the falling edge of the reference. With the default timing the frame is 900 ns and each slot is 25 ns. In every frame the block drives a bus-enable for the coprocessor, a buffer-enable for the host, and one SRAM write strobe that belongs to whichever master owns the current window.

The coprocessor owns the early part of the frame. The host gets the late part, but only when its decoded chip-select asks for the shared SRAM. When the host does not ask, the coprocessor keeps the bus until the end of the frame. Between the two windows there is always at least one slot in which neither master is enabled. The write strobe opens one slot after its owner's window opens and closes one slot before that window closes.

If a reference edge arrives at a slot where the counter does not expect it, the block starts a new frame from that edge and sets a sticky flag. It then holds both enables and the strobe off until a frame that lines up again.

Top module: `shared_sram_slot_seq`

## Requirements
- R1: While reset is held and after it is released, before any falling edge of `phaseRef` has been seen, `coBusEn`, `hostBufEn`, `sramWe` and `lockLost` are all low.
- R2: Take the first tick cycle in which `phaseRef` is sampled low after being sampled high. The tick after it is slot 0. Slots then count 0 to 35 and wrap. The first such edge after reset acquires lock without raising `lockLost`.
- R3: While locked, `coBusEn` is low in slot 0 and high in slots 1 to 23.
- R4: The value of `hostSel` during slot 23 decides the host grant for the frame. When that value is high, `hostBufEn` is high in slots 25 to 35 and `coBusEn` is low in slots 24 to 35. `hostSel` in any other slot has no effect.
- R5: When `hostSel` is low during slot 23, `coBusEn` stays high in slots 24 to 35 and `hostBufEn` stays low for the whole frame.
- R6: `coBusEn` and `hostBufEn` are never high in the same tick. Each one rises only after a tick in which the other was low.
- R7: When `coWr` is high during slot 1, `sramWe` is high in slots 2 to 22. When it is low, there is no coprocessor strobe in that frame. `coWr` in any other slot has no effect.
- R8: When the host is granted and `hostWr` is high during slot 25, `sramWe` is high in slots 26 to 34. Without a grant, or with `hostWr` low in slot 25, there is no host strobe. `sramWe` is high only while the owning enable is high.
- R9: A falling edge of `phaseRef` at any slot other than 35 restarts the count at slot 0 and drops lock. All three outputs stay low until the next falling edge that arrives exactly at slot 35, and normal operation resumes in the frame that edge starts.
- R10: `lockLost` goes high on the first misaligned edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseRef | input | 1 | Phase reference, synchronous to `clk`; falling edge marks frame start |
| hostSel | input | 1 | Host decoded chip-select for the shared SRAM |
| coWr | input | 1 | Coprocessor write intent for the current frame |
| hostWr | input | 1 | Host write intent for the current frame |
| coBusEn | output | 1 | Coprocessor bus-enable, active high |
| hostBufEn | output | 1 | Host buffer-enable, active high |
| sramWe | output | 1 | SRAM write strobe, active high |
| lockLost | output | 1 | Sticky flag: a reference edge arrived out of place |

## Verification
The hardest state to reach from the ports is a lost lock followed by a clean relock. This needs a reference edge that falls in the middle of a host window, after a grant is already active. The stimulus runs a locked frame with the reference high past slot 17, pulls it low at slot 27, and then keeps a steady 36-slot reference from that point. This checks that the frame after the bad edge is silent and that the frame after it is fully restored. Throughout, `hostSel`, `coWr` and `hostWr` are held at the opposite value in every slot except their sampling slot, so that any sampling in the wrong slot shows up at the outputs.

// File: rtl/slot_seq_pkg.sv
`timescale 1ns/1ps
package slot_seq_pkg;

  // Window strobes decoded by the control and consumed by the datapath.
  typedef struct packed {
    logic coWin;        // coprocessor owns the bus this slot
    logic hostWin;      // host buffer is open this slot
    logic coWrWin;      // coprocessor strobe may be active this slot
    logic hostWrWin;    // host strobe may be active this slot
    logic coCapture;    // slot in which coprocessor write intent is taken
    logic hostCapture;  // slot in which host write intent is taken
  } seqStrobes_t;

  localparam int NUM_MASTERS = 2;
  localparam int CO_IDX      = 0;
  localparam int HOST_IDX    = 1;

endpackage

// File: rtl/slot_seq_ctrl.sv
`timescale 1ns/1ps
module slot_seq_ctrl
  import slot_seq_pkg::*;
#(
  parameter int SLOTS     = 36,
  parameter int CO_LAST   = 23,
  parameter int HOST_OPEN = 25,
  parameter int WR_GUARD  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseRef,
  input  logic        hostSel,
  output seqStrobes_t strobes,
  output logic        lockLost
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_S       = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] CO_OPEN_S    = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] CO_LAST_S    = SLOT_W'(CO_LAST);
  localparam logic [SLOT_W-1:0] HOST_OPEN_S  = SLOT_W'(HOST_OPEN);
  localparam logic [SLOT_W-1:0] HOST_LAST_S  = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] SAMPLE_S     = SLOT_W'(CO_LAST);
  localparam logic [SLOT_W-1:0] CO_WR_LO_S   = SLOT_W'(1 + WR_GUARD);
  localparam logic [SLOT_W-1:0] CO_WR_HI_S   = SLOT_W'(CO_LAST - WR_GUARD);
  localparam logic [SLOT_W-1:0] HOST_WR_LO_S = SLOT_W'(HOST_OPEN + WR_GUARD);
  localparam logic [SLOT_W-1:0] HOST_WR_HI_S = SLOT_W'(SLOTS - 1 - WR_GUARD);

  logic [SLOT_W-1:0] slot;
  logic phPrev;
  logic locked;
  logic everLocked;
  logic hostGrant;
  logic fallNow;
  logic atLast;

  assign fallNow = phPrev & ~phaseRef;
  assign atLast  = (slot == LAST_S);

  // Slot counter, alignment tracking and lock state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot       <= '0;
      phPrev     <= 1'b0;
      locked     <= 1'b0;
      everLocked <= 1'b0;
      lockLost   <= 1'b0;
    end else begin
      phPrev <= phaseRef;
      if (fallNow) begin
        slot <= '0;
        if (atLast || !everLocked) begin
          locked     <= 1'b1;
          everLocked <= 1'b1;
        end else begin
          locked   <= 1'b0;
          lockLost <= 1'b1;
        end
      end else begin
        slot <= atLast ? '0 : slot + 1'b1;
      end
    end
  end

  // Host grant: taken once per frame, held to the frame end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostGrant <= 1'b0;
    end else if (fallNow || atLast) begin
      hostGrant <= 1'b0;
    end else if (slot == SAMPLE_S && locked) begin
      hostGrant <= hostSel;
    end
  end

  // Window decode from the current slot.
  always_comb begin
    strobes.coWin = locked &&
      (((slot >= CO_OPEN_S) && (slot <= CO_LAST_S)) ||
       ((slot > CO_LAST_S) && !hostGrant));
    strobes.hostWin   = locked && hostGrant &&
      (slot >= HOST_OPEN_S) && (slot <= HOST_LAST_S);
    strobes.coWrWin   = locked &&
      (slot >= CO_WR_LO_S) && (slot <= CO_WR_HI_S);
    strobes.hostWrWin = locked && hostGrant &&
      (slot >= HOST_WR_LO_S) && (slot <= HOST_WR_HI_S);
    strobes.coCapture   = (slot == CO_OPEN_S);
    strobes.hostCapture = (slot == HOST_OPEN_S);
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    slot <= LAST_S); // R2
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostGrant) |-> ($past(atLast) || $past(fallNow))); // R4
  AST_RELOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(fallNow)); // R9
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(lockLost)); // R10

endmodule

// File: rtl/slot_seq_dp.sv
`timescale 1ns/1ps
module slot_seq_dp
  import slot_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strobes,
  input  logic        coWr,
  input  logic        hostWr,
  output logic        coBusEn,
  output logic        hostBufEn,
  output logic        sramWe
);

  logic [NUM_MASTERS-1:0] wrReq;
  logic [NUM_MASTERS-1:0] capture;
  logic [NUM_MASTERS-1:0] wrWin;
  logic [NUM_MASTERS-1:0] wrHeld;

  assign wrReq[CO_IDX]     = coWr;
  assign wrReq[HOST_IDX]   = hostWr;
  assign capture[CO_IDX]   = strobes.coCapture;
  assign capture[HOST_IDX] = strobes.hostCapture;
  assign wrWin[CO_IDX]     = strobes.coWrWin;
  assign wrWin[HOST_IDX]   = strobes.hostWrWin;

  // Per-master write intent, taken once in the window-open slot.
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    logic held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        held <= 1'b0;
      else if (capture[m])
        held <= wrReq[m];
    end
    assign wrHeld[m] = held;
  end

  assign coBusEn   = strobes.coWin;
  assign hostBufEn = strobes.hostWin;
  assign sramWe    = |(wrHeld & wrWin);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(coBusEn && hostBufEn)); // R6
  AST_HOST_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostBufEn) |-> !$past(coBusEn)); // R6
  AST_CO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coBusEn) |-> !$past(hostBufEn)); // R6
  AST_WE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (coBusEn || hostBufEn)); // R8
  AST_WE_LATE_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWe) |-> ($past(coBusEn) || $past(hostBufEn))); // R7

endmodule

// File: rtl/shared_sram_slot_seq.sv
`timescale 1ns/1ps
module shared_sram_slot_seq
  import slot_seq_pkg::*;
#(
  parameter int SLOTS     = 36,
  parameter int CO_LAST   = 23,
  parameter int HOST_OPEN = 25,
  parameter int WR_GUARD  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic phaseRef,
  input  logic hostSel,
  input  logic coWr,
  input  logic hostWr,
  output logic coBusEn,
  output logic hostBufEn,
  output logic sramWe,
  output logic lockLost
);

  seqStrobes_t strobes;

  slot_seq_ctrl #(
    .SLOTS(SLOTS), .CO_LAST(CO_LAST), .HOST_OPEN(HOST_OPEN), .WR_GUARD(WR_GUARD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .phaseRef(phaseRef), .hostSel(hostSel),
    .strobes(strobes), .lockLost(lockLost)
  );

  slot_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .coWr(coWr), .hostWr(hostWr),
    .coBusEn(coBusEn), .hostBufEn(hostBufEn), .sramWe(sramWe)
  );

endmodule

// File: tb/shared_sram_slot_seq_bench.sv
`timescale 1ns/1ps
module shared_sram_slot_seq_bench;

  localparam int SLOTS = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseRef = 1'b1;
  logic hostSel = 1'b0;
  logic coWr = 1'b0;
  logic hostWr = 1'b0;
  logic coBusEn, hostBufEn, sramWe, lockLost;

  int checks = 0;
  int fails = 0;
  logic prevCo = 1'b0;
  logic prevHost = 1'b0;

  always #5 clk = ~clk;

  shared_sram_slot_seq u_shared_sram_slot_seq (
    .clk(clk), .rstN(rstN), .phaseRef(phaseRef), .hostSel(hostSel),
    .coWr(coWr), .hostWr(hostWr), .coBusEn(coBusEn), .hostBufEn(hostBufEn),
    .sramWe(sramWe), .lockLost(lockLost)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Per-tick overlap and dead-slot check (R6).
  task automatic checkGap(input int s);
    check(coBusEn && hostBufEn, 1'b0, "R6", $sformatf("overlap slot %0d", s));
    if (hostBufEn && !prevHost)
      check(prevCo, 1'b0, "R6", $sformatf("no gap before host slot %0d", s));
    if (coBusEn && !prevCo)
      check(prevHost, 1'b0, "R6", $sformatf("no gap before coprocessor slot %0d", s));
    prevCo = coBusEn;
    prevHost = hostBufEn;
  endtask

  // One full frame. Entry: mid slot 35 of prior timeline with phaseRef already low.
  task automatic runFrame(input bit hs, input bit cw, input bit hw, input bit lk, input bit lost);
    for (int s = 0; s < SLOTS; s++) begin
      @(negedge clk);
      begin
        bit eCo, eHost, eWe;
        eCo   = lk && ((s >= 1 && s <= 23) || (s >= 24 && !hs));
        eHost = lk && hs && s >= 25;
        eWe   = lk && ((cw && s >= 2 && s <= 22) || (hs && hw && s >= 26 && s <= 34));
        if (!lk) begin
          check(coBusEn, 1'b0, "R9", $sformatf("coBusEn while unlocked slot %0d", s));
          check(hostBufEn, 1'b0, "R9", $sformatf("hostBufEn while unlocked slot %0d", s));
          check(sramWe, 1'b0, "R9", $sformatf("sramWe while unlocked slot %0d", s));
        end else begin
          check(coBusEn, eCo, (s >= 24) ? (hs ? "R4" : "R5") : "R3",
                $sformatf("coBusEn slot %0d", s));
          check(hostBufEn, eHost, hs ? "R4" : "R5", $sformatf("hostBufEn slot %0d", s));
          check(sramWe, eWe, (s < 24) ? "R7" : "R8", $sformatf("sramWe slot %0d", s));
          if (s == 1) check(coBusEn, 1'b1, "R2", "first slot after frame start");
        end
        check(lockLost, lost, lost ? "R10" : "R2", $sformatf("lockLost slot %0d", s));
        checkGap(s);
      end
      phaseRef = (s <= 16 || s == 35) ? 1'b0 : 1'b1;
      hostSel  = (s == 23) ? hs : !hs;
      coWr     = (s == 1)  ? cw : !cw;
      hostWr   = (s == 25) ? hw : !hw;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(coBusEn, 1'b0, "R1", "coBusEn in reset");
    check(hostBufEn, 1'b0, "R1", "hostBufEn in reset");
    check(sramWe, 1'b0, "R1", "sramWe in reset");
    check(lockLost, 1'b0, "R1", "lockLost in reset");
    rstN = 1'b1;
    coWr = 1'b1; hostWr = 1'b1; hostSel = 1'b1;
    repeat (50) begin
      @(negedge clk);
      check(coBusEn || hostBufEn || sramWe || lockLost, 1'b0, "R1", "outputs before first edge");
    end
  endtask

  task automatic testAcquire();
    phaseRef = 1'b0;  // first falling edge, seen at the next posedge
    runFrame(1, 1, 1, 1, 0);
  endtask

  task automatic testFrameMix();
    runFrame(0, 1, 1, 1, 0);  // host not selected: host write ignored
    runFrame(1, 0, 0, 1, 0);
    runFrame(1, 1, 0, 1, 0);
    runFrame(0, 0, 0, 1, 0);
    runFrame(1, 0, 1, 1, 0);
  endtask

  task automatic testMisalign();
    for (int s = 0; s <= 27; s++) begin
      @(negedge clk);
      check(hostBufEn, (s >= 25) ? 1'b1 : 1'b0, "R4", $sformatf("pre-slip hostBufEn slot %0d", s));
      check(coBusEn, (s >= 1 && s <= 23) ? 1'b1 : 1'b0, "R3", $sformatf("pre-slip coBusEn slot %0d", s));
      checkGap(s);
      phaseRef = (s == 27) ? 1'b0 : ((s <= 16) ? 1'b0 : 1'b1);
      hostSel  = 1'b1;
      coWr     = 1'b0;
      hostWr   = 1'b0;
    end
    runFrame(1, 1, 1, 0, 1);  // silent frame after the slip
    runFrame(1, 1, 1, 1, 1);  // relocked frame, flag still set
    runFrame(0, 1, 0, 1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testAcquire();
    testFrameMix();
    testMisalign();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule